// File: doc/BRIEF.md
# Configurable Two-Plane Logic Array

This block is a small sum-of-products logic array whose whole function is set by stored configuration bits. Each logic input is offered in its true and inverted forms. A programmable AND plane combines a chosen set of these literals into each product term. A programmable OR plane then gathers any chosen set of product terms into each output, so one term can serve every output. A final per-output polarity bit can invert the sum, which lets an output realise a product-of-sums form.

Configuration arrives one bit per clock on a serial chain while the load enable is high. During a load the outputs are forced low, so a half-written pattern never reaches them. Once the enable drops, the stored pattern holds, and the outputs follow the logic inputs through combinational paths only, with no clock in the data path. The input, output and product-term counts are parameters. The defaults are 3 inputs, 2 outputs and 4 terms, which gives a 34-bit chain.

Top module: `pla_emu`

## Requirements
- R1: Product term t is the AND of every literal whose AND-plane bit is set. Input i (lgc_in[i]; lgc_in[0]=A, lgc_in[1]=B, lgc_in[2]=C) supplies literal index 2*i for its true form and 2*i+1 for its inverted form.
- R2: Output o (before polarity) is the OR of every product term whose OR-plane bit for (o, t) is set. One term may feed several outputs at once.
- R3: When the polarity bit of output o is 1, that output is the inverse of its OR-plane sum. When the bit is 0, the output equals the sum.
- R4: A product term with no literal selected is 1. An output with no term selected has a sum of 0, before polarity is applied.
- R5: A product term that selects both the true and the inverted literal of the same input is 0 for every input value.
- R6: While cfg_en is 1, each clock shifts cfg_din into the chain. After exactly W = 2*N_IN*N_TERM + N_OUT*N_TERM + N_OUT shifts, the k-th bit shifted in, counting from 0, controls chain index k. AND bit (t,i,c) sits at index t*2*N_IN + 2*i + c. OR bit (o,t) sits at 2*N_IN*N_TERM + o*N_TERM + t. Polarity bit o sits at 2*N_IN*N_TERM + N_OUT*N_TERM + o.
- R7: While cfg_en is 1, every output is 0, whatever the inputs and the stored bits are.
- R8: A synchronous active-high rst clears every configuration bit. Afterwards every output is 0 for every input value.
- R9: While cfg_en is 0, the stored configuration does not change, whatever cfg_din does. The outputs follow lgc_in without any clock edge.
- R10: With the default sizes, one configuration gives A·B + B·C + A·C on output 0 and A xor B on output 1. Output 1 is built as the inverted sum of A·B and A'·B', and it shares the A·B term with output 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset; clears the configuration |
| cfg_en | input | 1 | Load enable; shifts the chain and blanks the outputs |
| cfg_din | input | 1 | Serial configuration data |
| lgc_in | input | N_IN | Logic inputs |
| lgc_out | output | N_OUT | Logic outputs |

## Verification
Each stored pattern is swept over all eight input combinations. The cases and what each one shows:
- **Single term with a true and an inverted literal, driven to both outputs with opposite polarity.** Exposes a swapped true and inverted literal, a misplaced literal index, and a wrong polarity sense.
- **A literal-free term, a self-contradicting term and an output with no terms.** Pin down the constant corner cases of both planes.
- **The majority and exclusive-or pair.** Shows term sharing across outputs and confirms the full shift order of the chain.
- **Toggling cfg_din during sweeps, blanking checks in the middle of a load, and a reset after a live configuration.** Separate holding from shifting, blanking from stale outputs, and a cleared chain from a merely idle one.

// File: rtl/pla_pkg.sv
package pla_pkg;

  function automatic int unsigned cfg_width(input int unsigned n_in,
                                            input int unsigned n_out,
                                            input int unsigned n_term);
    return 2 * n_in * n_term + n_out * n_term + n_out;
  endfunction

  function automatic int unsigned lit_index(input int unsigned inp,
                                            input int unsigned inv);
    return 2 * inp + inv;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int unsigned W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] cfg_q
);

  // Newest bit enters at the top; after W shifts the first bit sits at index 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (shift_en) begin
      if (W > 1) begin
        cfg_q <= {ser_in, cfg_q[W-1:1]};
      end else begin
        cfg_q <= ser_in;
      end
    end
  end

endmodule

// File: rtl/pla_lit_gen.sv
module pla_lit_gen #(
  parameter int unsigned N_IN = 3,
  localparam int unsigned LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]  in_vec,
  output logic [LIT_W-1:0] lits
);

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[pla_pkg::lit_index(i, 0)] = in_vec[i];
    assign lits[pla_pkg::lit_index(i, 1)] = ~in_vec[i];
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_TERM = 4,
  localparam int unsigned LIT_W = 2 * N_IN,
  localparam int unsigned CFG_W = LIT_W * N_TERM
) (
  input  logic [LIT_W-1:0]  lits,
  input  logic [CFG_W-1:0]  and_cfg,
  output logic [N_TERM-1:0] terms
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LIT_W-1:0] sel;
    assign sel      = and_cfg[t*LIT_W +: LIT_W];
    // Unselected literals are forced to 1, so an empty term is 1.
    assign terms[t] = &(lits | ~sel);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 4,
  parameter int unsigned N_OUT  = 2,
  localparam int unsigned CFG_W = N_TERM * N_OUT
) (
  input  logic [N_TERM-1:0] terms,
  input  logic [CFG_W-1:0]  or_cfg,
  output logic [N_OUT-1:0]  sums
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sums[o] = |(terms & or_cfg[o*N_TERM +: N_TERM]);
  end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int unsigned N_OUT = 2
) (
  input  logic [N_OUT-1:0] sums,
  input  logic [N_OUT-1:0] pol,
  input  logic             blank,
  output logic [N_OUT-1:0] outs
);

  always_comb begin
    if (blank) begin
      outs = '0;
    end else begin
      outs = sums ^ pol;
    end
  end

endmodule

// File: rtl/pla_emu.sv
module pla_emu #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_OUT  = 2,
  parameter int unsigned N_TERM = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  lgc_in,
  output logic [N_OUT-1:0] lgc_out
);

  localparam int unsigned LIT_W = 2 * N_IN;
  localparam int unsigned AND_W = LIT_W * N_TERM;
  localparam int unsigned OR_W  = N_OUT * N_TERM;
  localparam int unsigned W     = pla_pkg::cfg_width(N_IN, N_OUT, N_TERM);

  logic [W-1:0]      cfg_q;
  logic [LIT_W-1:0]  lits;
  logic [N_TERM-1:0] terms;
  logic [N_OUT-1:0]  sums;

  pla_cfg_chain #(.W(W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .ser_in   (cfg_din),
    .cfg_q    (cfg_q)
  );

  pla_lit_gen #(.N_IN(N_IN)) u_lits (
    .in_vec (lgc_in),
    .lits   (lits)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .lits    (lits),
    .and_cfg (cfg_q[AND_W-1:0]),
    .terms   (terms)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .terms  (terms),
    .or_cfg (cfg_q[AND_W+OR_W-1:AND_W]),
    .sums   (sums)
  );

  pla_out_stage #(.N_OUT(N_OUT)) u_out (
    .sums  (sums),
    .pol   (cfg_q[W-1:AND_W+OR_W]),
    .blank (cfg_en),
    .outs  (lgc_out)
  );

endmodule

// File: rtl/pla_emu_chk.sv
module pla_emu_chk #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_OUT  = 2,
  parameter int unsigned N_TERM = 4,
  localparam int unsigned LIT_W = 2 * N_IN,
  localparam int unsigned W     = pla_pkg::cfg_width(N_IN, N_OUT, N_TERM)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              cfg_din,
  input logic [N_OUT-1:0]  lgc_out,
  input logic [W-1:0]      cfg_q,
  input logic [N_TERM-1:0] terms
);

  // R7: loading blanks every output
  p_blank_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (lgc_out == '0));

  // R8: the cycle after reset the chain is empty
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == '0));

  // R9: idle chain keeps its contents
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));

  // R6: serial bit enters at the top and the rest moves down one place
  p_shift_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> ((cfg_q[W-1] == $past(cfg_din)) &&
                (cfg_q[W-2:0] == $past(cfg_q[W-1:1]))));

  for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
    // R4: a term with nothing selected is 1
    p_empty_term_r4: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[t*LIT_W +: LIT_W] == '0) |-> terms[t]);
    for (genvar i = 0; i < N_IN; i++) begin : g_in_chk
      // R5: true and inverted literal of one input together give 0
      p_contra_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[t*LIT_W + 2*i] && cfg_q[t*LIT_W + 2*i + 1]) |-> !terms[t]);
    end
  end

endmodule

bind pla_emu pla_emu_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_en  (cfg_en),
  .cfg_din (cfg_din),
  .lgc_out (lgc_out),
  .cfg_q   (cfg_q),
  .terms   (terms)
);

// File: tb/tb_pla_emu.sv
module tb_pla_emu;

  localparam int NI = 3;
  localparam int NO = 2;
  localparam int NT = 4;
  localparam int AW = 2 * NI * NT;
  localparam int OW = NO * NT;
  localparam int W  = AW + OW + NO;

  typedef struct {
    logic [NO-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_din = 1'b0;
  logic [NI-1:0] lgc_in = '0;
  logic [NO-1:0] lgc_out;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  item_t sb[$];
  logic [W-1:0] bld;
  logic [W-1:0] cur;

  always #5 clk = ~clk;

  pla_emu #(.N_IN(NI), .N_OUT(NO), .N_TERM(NT)) dut (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .lgc_in  (lgc_in),
    .lgc_out (lgc_out)
  );

  // Reference evaluation written from the requirements
  function automatic logic [NO-1:0] model(input logic [W-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] tm;
    logic [NO-1:0] r;
    for (int t = 0; t < NT; t++) begin
      tm[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[t*2*NI + 2*i] && !x[i]) tm[t] = 1'b0;
        if (c[t*2*NI + 2*i + 1] && x[i]) tm[t] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < NT; t++) begin
        if (c[AW + o*NT + t] && tm[t]) r[o] = 1'b1;
      end
      r[o] = r[o] ^ c[AW + OW + o];
    end
    return r;
  endfunction

  task automatic lit(input int t, input int i, input int inv);
    bld[t*2*NI + 2*i + inv] = 1'b1;
  endtask

  task automatic link(input int o, input int t);
    bld[AW + o*NT + t] = 1'b1;
  endtask

  task automatic inv_out(input int o);
    bld[AW + OW + o] = 1'b1;
  endtask

  task automatic push(input logic [NO-1:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic load(input logic [W-1:0] v);
    for (int k = 0; k < W; k++) begin
      @(posedge clk); #1;
      cfg_en  = 1'b1;
      cfg_din = v[k];
      lgc_in  = NI'(k);
      if (k == W / 2 || k == 1) push('0, "R7 blank during load");
    end
    @(posedge clk); #1;
    cfg_en = 1'b0;
    cur    = v;
  endtask

  task automatic sweep(input string tag);
    for (int x = 0; x < (1 << NI); x++) begin
      @(posedge clk); #1;
      lgc_in  = NI'(x);
      cfg_din = x[0] ^ x[1];
      push(model(cur, NI'(x)), tag);
    end
  endtask

  // Monitor: compares one queued expectation per cycle, away from the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (lgc_out !== it.exp) begin
        n_bad++;
        $display("FAIL %s in=%b actual=%b expected=%b", it.tag, lgc_in, lgc_out, it.exp);
      end
    end
  end

  initial begin
    cur = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    sweep("R8 reset state");

    // Config A: T0 = A & ~C, out0 = T0, out1 = ~T0
    bld = '0;
    lit(0, 0, 0); lit(0, 2, 1);
    link(0, 0); link(1, 0); inv_out(1);
    load(bld);
    sweep("R1 R2 R3 R9 single term shared, opposite polarity");

    // Config B: T0 empty -> out0; T1 = A & ~A -> out1
    bld = '0;
    lit(1, 0, 0); lit(1, 0, 1);
    link(0, 0); link(1, 1);
    load(bld);
    sweep("R4 R5 empty term and contradiction");

    // Config D: no terms anywhere, out1 inverted
    bld = '0;
    inv_out(1);
    load(bld);
    sweep("R4 R3 empty output sums");

    // Config C: majority and exclusive-or with a shared A&B term
    bld = '0;
    lit(0, 0, 0); lit(0, 1, 0);
    lit(1, 1, 0); lit(1, 2, 0);
    lit(2, 0, 0); lit(2, 2, 0);
    lit(3, 0, 1); lit(3, 1, 1);
    link(0, 0); link(0, 1); link(0, 2);
    link(1, 0); link(1, 3); inv_out(1);
    load(bld);
    for (int x = 0; x < (1 << NI); x++) begin
      logic a, b, c;
      a = x[0]; b = x[1]; c = x[2];
      @(posedge clk); #1;
      lgc_in = NI'(x);
      push({a ^ b, (a & b) | (b & c) | (a & c)}, "R10 R6 majority and xor");
    end

    // Reset after a live configuration
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    cur = '0;
    sweep("R8 reset clears live config");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule